// File: doc/BRIEF.md
# Descriptor-Table Scatter-Gather DMA Engine

This block is a bus-master DMA engine. It follows a table of 8-byte region descriptors kept in system memory and moves bytes between a device-side byte stream and the memory regions those descriptors name. Every descriptor gives a buffer address and a byte count, with an end-of-table flag in the top bit of the count. The engine reads each descriptor over its own memory master port. It then copies data in beats of one to four bytes, writing to memory or reading from it as the direction input selects, until one of two things happens: the device's byte count is satisfied, or the table runs out.

A register block supplies the table base, the direction and the device byte count, and starts a walk with a one-cycle `go` pulse. A `rewind` pulse, given while the engine is idle, walks the same table again from its base and continues with the device bytes still owed. At the end of each walk the engine raises one-cycle pulses: `done` when the device count was met, `eot` when the table was exhausted, and `underrun` when the table ended before the count was met. As a safety limit, the engine never reads a descriptor that lies 4096 or more bytes past the table base.

Memory requests use a valid/ready handshake. A read returns its data with `mem_rvalid` in some later cycle, and only one request is outstanding at a time. Data is carried LSB-first: byte 0 of the data bus belongs to `mem_addr`, byte 1 to `mem_addr+1`, and so on, for `mem_nbytes` bytes. Buffer addresses need not be aligned.

Top module: `prd_walker`

## Requirements
- R1: A descriptor is read as two 4-byte little-endian reads. The word at the fetch pointer is the buffer address and the word at fetch pointer + 4 is the count word. The fetch pointer then advances by 8, and the region's bytes go to consecutive addresses starting at the buffer address.
- R2: The region length is count word bits [15:0] with bit 0 forced to zero. A resulting value of zero means 65536 bytes.
- R3: Count word bit 31 marks the last descriptor. Once that region is used up and the device still needs bytes, the walk ends with an `eot` pulse and reads no further descriptor.
- R4: The next descriptor is read only after the current region is fully used. Each move is limited by whichever is smaller, the bytes the device still owes or the bytes left in the region, so a satisfied device count leaves the rest of the region untouched.
- R5: No descriptor is read at a fetch pointer 4096 or more bytes past the table base. Reaching that point with the region used up ends the walk with `eot`.
- R6: With `to_mem`=1, device bytes taken on `dev_take` are written to memory. With `to_mem`=0, memory is read and the bytes are handed to the device on `dev_push`. Each beat carries `dev_nbytes` bytes, LSB-first.
- R7: `done` pulses for one cycle in the cycle `busy` falls when the device count has been met. A device count of zero gives `done` with no memory access. No memory request is made while idle.
- R8: `underrun` pulses, together with `eot` and never with `done`, when the table ends before the device count is met.
- R9: Every memory request carries 1 to 4 bytes and holds its address, size and direction stable until `mem_ready`.
- R10: `go` is ignored while busy. The two low bits of `table_base` are ignored, so the table is word aligned.
- R11: `rewind` while idle restarts the walk at the latched table base, with the current region cleared and the remaining device count kept. `table_base` and `dev_count` are not sampled. `go` takes priority over `rewind`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| go | input | 1 | Start pulse: latch base, count and direction, begin walk |
| rewind | input | 1 | Restart the walk from the latched base, keeping remaining count |
| to_mem | input | 1 | 1: device-to-memory, 0: memory-to-device |
| table_base | input | 32 | Descriptor table address (bits 1:0 ignored) |
| dev_count | input | CNT_W | Bytes the device needs moved |
| dev_wdata | input | 32 | Next device bytes, LSB first, for memory writes |
| dev_take | output | 1 | Device bytes consumed this cycle |
| dev_push | output | 1 | Bytes delivered to the device this cycle |
| dev_rdata | output | 32 | Bytes for the device, LSB first |
| dev_nbytes | output | 3 | Byte count of the take or push beat |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Byte address of the request |
| mem_nbytes | output | 3 | Bytes in the request, 1 to 4 |
| mem_wdata | output | 32 | Write data, LSB first |
| mem_ready | input | 1 | Memory accepts the request |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data, LSB first |
| busy | output | 1 | A walk is in progress |
| done | output | 1 | Pulse: device count met |
| eot | output | 1 | Pulse: table exhausted |
| underrun | output | 1 | Pulse: table ended before count met |

## Verification
The assertions check, on every cycle, the request rules: a request holds its address, size and direction until accepted; a beat carries one to four bytes; and nothing is requested while idle. They also check how the end pulses relate, with `underrun` always joined by `eot`, never by `done`, and `done` only as the engine goes idle. Several behaviours show only in the bench's scenarios, which compare memory contents, bytes delivered to the device and descriptor-read counts with values worked out from each table: the length decoding, with bit 0 dropped and zero read as 64 KiB; the smaller-of-two chunk rule; the one-page table limit; `go` being ignored while busy; and a rewind continuing the remaining count.

// File: rtl/prd_pkg.sv
// Shared types and constants for the descriptor-walking DMA engine.
package prd_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK,
        ST_FREQ,
        ST_FWAIT,
        ST_MREQ,
        ST_MWAIT
    } walk_st_t;

    localparam int unsigned DESC_BYTES = 8;
    localparam int unsigned BEAT_MAX   = 4;
    localparam int unsigned LEN_W      = 17;
endpackage

// File: rtl/prd_decode.sv
// Count-word decoder. Turns the low half and the top flag of a descriptor
// count word into a region length and a last-descriptor flag.
// Assumes: caller passes count bits [15:0] and bit 31 separately.
module prd_decode
    import prd_pkg::*;
(
    input  logic [15:0]      cnt_lo,
    input  logic             cnt_flag,
    output logic [LEN_W-1:0] len,
    output logic             last
);
    logic [15:0] even_cnt;

    // Drop bit 0 and map a zero length to the 64 KiB maximum.
    always_comb begin
        even_cnt = cnt_lo & 16'hFFFE;
        if (even_cnt == 16'd0) len = LEN_W'(32'h1_0000);
        else                   len = LEN_W'(even_cnt);
        last = cnt_flag;
    end
endmodule

// File: rtl/prd_beat_size.sv
// Beat sizer. Picks the byte count of the next data beat as the smallest
// of the beat limit, the bytes owed to the device and the region bytes left.
// Assumes: only used when both counts are nonzero.
module prd_beat_size
    import prd_pkg::*;
#(
    parameter int unsigned CNT_W = 20
) (
    input  logic [CNT_W-1:0] dev_rem,
    input  logic [LEN_W-1:0] reg_len,
    output logic [2:0]       beat
);
    // Three-way minimum, narrowed to the beat width.
    always_comb begin
        beat = 3'(BEAT_MAX);
        if (dev_rem < CNT_W'(BEAT_MAX)) beat = 3'(dev_rem);
        if (reg_len < LEN_W'(beat))     beat = 3'(reg_len);
    end
endmodule

// File: rtl/prd_table_guard.sv
// End-of-table detector. Reports the table as used up when the current
// region is empty and either the last flag was seen or the fetch pointer
// has moved a full page past the table base.
// Assumes: fetch_ptr never falls below base (it only grows from it).
module prd_table_guard
    import prd_pkg::*;
#(
    parameter int unsigned PAGE_BYTES = 4096
) (
    input  logic [31:0]      fetch_ptr,
    input  logic [31:0]      base,
    input  logic             last_seen,
    input  logic [LEN_W-1:0] reg_len,
    output logic             exhausted
);
    logic [31:0] walked;

    // Distance walked and the combined stop condition.
    always_comb begin
        walked    = fetch_ptr - base;
        exhausted = (reg_len == '0) &&
                    (last_seen || (walked >= 32'(PAGE_BYTES)));
    end
endmodule

// File: rtl/prd_walker.sv
// Descriptor-table scatter-gather DMA engine (top).
// Walks 8-byte descriptors from memory and moves device bytes to or from
// the regions they name, in beats of up to 4 bytes, one memory request
// outstanding at a time.
// Assumes: the device can always supply (dev_take) or accept (dev_push)
// a beat in the cycle it is signalled; read data returns in order.
module prd_walker
    import prd_pkg::*;
#(
    parameter int unsigned CNT_W      = 20,
    parameter int unsigned PAGE_BYTES = 4096
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic             rewind,
    input  logic             to_mem,
    input  logic [31:0]      table_base,
    input  logic [CNT_W-1:0] dev_count,
    input  logic [31:0]      dev_wdata,
    output logic             dev_take,
    output logic             dev_push,
    output logic [31:0]      dev_rdata,
    output logic [2:0]       dev_nbytes,
    output logic             mem_req,
    output logic             mem_we,
    output logic [31:0]      mem_addr,
    output logic [2:0]       mem_nbytes,
    output logic [31:0]      mem_wdata,
    input  logic             mem_ready,
    input  logic             mem_rvalid,
    input  logic [31:0]      mem_rdata,
    output logic             busy,
    output logic             done,
    output logic             eot,
    output logic             underrun
);
    localparam logic [31:0] DESC_STEP = 32'(DESC_BYTES);
    localparam logic [31:0] WORD_STEP = 32'(DESC_BYTES / 2);

    walk_st_t         state;
    logic [31:0]      base_q;
    logic [31:0]      fetch_ptr;
    logic [31:0]      reg_addr;
    logic [LEN_W-1:0] reg_len;
    logic             reg_last;
    logic [CNT_W-1:0] dev_rem;
    logic             dir_q;
    logic             word_sel;
    logic [2:0]       beat_q;

    logic [LEN_W-1:0] dec_len;
    logic             dec_last;
    logic [2:0]       beat;
    logic             exhausted;

    prd_decode u_decode (
        .cnt_lo   (mem_rdata[15:0]),
        .cnt_flag (mem_rdata[31]),
        .len      (dec_len),
        .last     (dec_last)
    );

    prd_beat_size #(.CNT_W(CNT_W)) u_beat (
        .dev_rem (dev_rem),
        .reg_len (reg_len),
        .beat    (beat)
    );

    prd_table_guard #(.PAGE_BYTES(PAGE_BYTES)) u_guard (
        .fetch_ptr (fetch_ptr),
        .base      (base_q),
        .last_seen (reg_last),
        .reg_len   (reg_len),
        .exhausted (exhausted)
    );

    // Memory and device side outputs decoded from the walk state.
    always_comb begin
        mem_req    = (state == ST_FREQ) || (state == ST_MREQ);
        mem_we     = (state == ST_MREQ) && dir_q;
        mem_addr   = (state == ST_FREQ) ? (fetch_ptr + (word_sel ? WORD_STEP : 32'd0))
                                        : reg_addr;
        mem_nbytes = (state == ST_FREQ) ? 3'(BEAT_MAX) : beat;
        mem_wdata  = dev_wdata;
        dev_take   = (state == ST_MREQ) && dir_q && mem_ready;
        dev_push   = (state == ST_MWAIT) && mem_rvalid;
        dev_rdata  = mem_rdata;
        dev_nbytes = (state == ST_MWAIT) ? beat_q : beat;
        busy       = (state != ST_IDLE);
    end

    // Walk sequencer: start, descriptor fetch, data beats and end pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            base_q    <= '0;
            fetch_ptr <= '0;
            reg_addr  <= '0;
            reg_len   <= '0;
            reg_last  <= 1'b0;
            dev_rem   <= '0;
            dir_q     <= 1'b0;
            word_sel  <= 1'b0;
            beat_q    <= '0;
            done      <= 1'b0;
            eot       <= 1'b0;
            underrun  <= 1'b0;
        end else begin
            done     <= 1'b0;
            eot      <= 1'b0;
            underrun <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (go) begin
                        base_q    <= table_base & ~32'h3;
                        fetch_ptr <= table_base & ~32'h3;
                        dev_rem   <= dev_count;
                        dir_q     <= to_mem;
                        reg_addr  <= '0;
                        reg_len   <= '0;
                        reg_last  <= 1'b0;
                        word_sel  <= 1'b0;
                        state     <= ST_CHECK;
                    end else if (rewind) begin
                        fetch_ptr <= base_q;
                        dir_q     <= to_mem;
                        reg_addr  <= '0;
                        reg_len   <= '0;
                        reg_last  <= 1'b0;
                        word_sel  <= 1'b0;
                        state     <= ST_CHECK;
                    end
                end
                ST_CHECK: begin
                    if (dev_rem == '0) begin
                        done  <= 1'b1;
                        eot   <= exhausted;
                        state <= ST_IDLE;
                    end else if (reg_len == '0) begin
                        if (exhausted) begin
                            eot      <= 1'b1;
                            underrun <= 1'b1;
                            state    <= ST_IDLE;
                        end else begin
                            word_sel <= 1'b0;
                            state    <= ST_FREQ;
                        end
                    end else begin
                        state <= ST_MREQ;
                    end
                end
                ST_FREQ: begin
                    if (mem_ready) state <= ST_FWAIT;
                end
                ST_FWAIT: begin
                    if (mem_rvalid) begin
                        if (!word_sel) begin
                            reg_addr <= mem_rdata;
                            word_sel <= 1'b1;
                            state    <= ST_FREQ;
                        end else begin
                            reg_len   <= dec_len;
                            reg_last  <= dec_last;
                            fetch_ptr <= fetch_ptr + DESC_STEP;
                            word_sel  <= 1'b0;
                            state     <= ST_CHECK;
                        end
                    end
                end
                ST_MREQ: begin
                    if (mem_ready) begin
                        reg_addr <= reg_addr + 32'(beat);
                        reg_len  <= reg_len - LEN_W'(beat);
                        dev_rem  <= dev_rem - CNT_W'(beat);
                        beat_q   <= beat;
                        state    <= dir_q ? ST_CHECK : ST_MWAIT;
                    end
                end
                ST_MWAIT: begin
                    if (mem_rvalid) state <= ST_CHECK;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/prd_walker_chk.sv
// Protocol checker for prd_walker, attached by bind below.
// Assumes: synchronous active-low reset on rst_n.
module prd_walker_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        busy,
    input logic        mem_req,
    input logic        mem_we,
    input logic        mem_ready,
    input logic [31:0] mem_addr,
    input logic [2:0]  mem_nbytes,
    input logic        done,
    input logic        eot,
    input logic        underrun
);
    // R9: a pending request is held unchanged until accepted.
    a_r9_hold_until_ready: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ready |=> mem_req && $stable(mem_addr) &&
                                  $stable(mem_nbytes) && $stable(mem_we));

    // R9: each beat carries one to four bytes.
    a_r9_beat_range: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_nbytes >= 3'd1) && (mem_nbytes <= 3'd4));

    // R8: underrun always comes with end of table.
    a_r8_underrun_with_eot: assert property (@(posedge clk) disable iff (!rst_n)
        underrun |-> eot);

    // R8: underrun and done never coincide.
    a_r8_not_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && underrun));

    // R7: no memory traffic while idle.
    a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req);

    // R7: done marks the return to idle.
    a_r7_done_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
endmodule

bind prd_walker prd_walker_chk i_prd_walker_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_ready  (mem_ready),
    .mem_addr   (mem_addr),
    .mem_nbytes (mem_nbytes),
    .done       (done),
    .eot        (eot),
    .underrun   (underrun)
);

// File: tb/test_prd_walker.sv
`timescale 1ns/1ps
module test_prd_walker;
    localparam int CNT_W = 20;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             go = 1'b0;
    logic             rewind = 1'b0;
    logic             to_mem = 1'b0;
    logic [31:0]      table_base = '0;
    logic [CNT_W-1:0] dev_count = '0;
    logic [31:0]      dev_wdata;
    logic             dev_take, dev_push;
    logic [31:0]      dev_rdata;
    logic [2:0]       dev_nbytes;
    logic             mem_req, mem_we;
    logic [31:0]      mem_addr, mem_wdata;
    logic [2:0]       mem_nbytes;
    logic             mem_ready, mem_rvalid;
    logic [31:0]      mem_rdata;
    logic             busy, done, eot, underrun;

    always #4 clk = ~clk;

    prd_walker #(.CNT_W(CNT_W)) i_prd_walker (
        .clk(clk), .rst_n(rst_n), .go(go), .rewind(rewind), .to_mem(to_mem),
        .table_base(table_base), .dev_count(dev_count), .dev_wdata(dev_wdata),
        .dev_take(dev_take), .dev_push(dev_push), .dev_rdata(dev_rdata),
        .dev_nbytes(dev_nbytes), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_nbytes(mem_nbytes), .mem_wdata(mem_wdata),
        .mem_ready(mem_ready), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .busy(busy), .done(done), .eot(eot), .underrun(underrun)
    );

    int checks = 0;
    int errors = 0;

    bit [7:0] mem [int unsigned];
    bit [7:0] rx  [int];

    function automatic bit [7:0] rd8(input int unsigned a);
        return mem.exists(a) ? mem[a] : 8'h00;
    endfunction

    function automatic bit [7:0] pat(input int k);
        return 8'(k * 7 + 3);
    endfunction

    function automatic bit [7:0] src(input int unsigned a);
        return 8'(a ^ (a >> 8));
    endfunction

    // Memory model: optional stalls, read data one cycle after accept.
    int          cyc = 0;
    int          nreads = 0;
    logic        stall_mode = 1'b0;
    logic        rvalid_q = 1'b0;
    logic [31:0] rdata_q = '0;
    assign mem_ready  = !stall_mode || ((cyc % 3) != 1);
    assign mem_rvalid = rvalid_q;
    assign mem_rdata  = rdata_q;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        rvalid_q <= 1'b0;
        if (rst_n && mem_req && mem_ready) begin
            if (mem_we) begin
                for (int i = 0; i < int'(mem_nbytes); i++)
                    mem[mem_addr + i] = mem_wdata[8*i +: 8];
            end else begin
                logic [31:0] w;
                w = '0;
                for (int i = 0; i < int'(mem_nbytes); i++)
                    w[8*i +: 8] = rd8(mem_addr + i);
                rdata_q  <= w;
                rvalid_q <= 1'b1;
                nreads   <= nreads + 1;
            end
        end
    end

    // Device model: byte stream indexed by devpos.
    int devpos = 0;
    assign dev_wdata = {pat(devpos + 3), pat(devpos + 2), pat(devpos + 1), pat(devpos)};

    always @(posedge clk) begin
        if (dev_take) devpos <= devpos + int'(dev_nbytes);
        if (dev_push) begin
            for (int i = 0; i < int'(dev_nbytes); i++)
                rx[devpos + i] = dev_rdata[8*i +: 8];
            devpos <= devpos + int'(dev_nbytes);
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic chk_eq(input string req, input string what,
                          input longint act, input longint exp);
        check(act == exp, req, what, act, exp);
    endtask

    task automatic put32(input int unsigned a, input logic [31:0] v);
        for (int i = 0; i < 4; i++) mem[a + i] = v[8*i +: 8];
    endtask

    task automatic put_desc(input int unsigned tbl, input int idx,
                            input logic [31:0] bufa, input logic [31:0] cnt);
        put32(tbl + 8*idx, bufa);
        put32(tbl + 8*idx + 4, cnt);
    endtask

    // Compare a written memory region against the device pattern.
    task automatic chk_region(input string req, input int unsigned a,
                              input int len, input int k0);
        int bad;
        bad = 0;
        for (int i = 0; i < len; i++)
            if (rd8(a + i) != pat(k0 + i)) bad++;
        chk_eq(req, "region bytes mismatching", bad, 0);
    endtask

    bit r_done, r_eot, r_under;
    int r_moved, r_reads, r_p0;

    // Start a walk (go or rewind), optionally poke go mid-walk, wait for idle.
    task automatic launch(input bit use_rewind, input logic [31:0] base,
                          input int cnt, input bit dir, input int poke);
        int n0, n;
        r_p0 = devpos;
        n0 = nreads;
        r_done = 0; r_eot = 0; r_under = 0;
        @(negedge clk);
        table_base = base;
        dev_count  = CNT_W'(cnt);
        to_mem     = dir;
        go         = !use_rewind;
        rewind     = use_rewind;
        @(negedge clk);
        go = 0; rewind = 0;
        n = 0;
        forever begin
            if (done) r_done = 1;
            if (eot) r_eot = 1;
            if (underrun) r_under = 1;
            if (!busy) break;
            if (poke != 0 && n == poke) begin
                go = 1; table_base = 32'h7000; dev_count = 3; to_mem = 0;
            end else begin
                go = 0;
            end
            @(negedge clk);
            n++;
            if (n > 150000) break;
        end
        go = 0;
        r_moved = devpos - r_p0;
        r_reads = nreads - n0;
    endtask

    task automatic finish_up;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

    localparam int unsigned TB = 32'h1000;

    initial begin
        repeat (3) @(negedge clk);
        // Reset state (R7): idle, no request, no pulses.
        chk_eq("R7", "busy in reset", busy, 0);
        chk_eq("R7", "mem_req in reset", mem_req, 0);
        chk_eq("R7", "done in reset", done, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Table of three: lengths 6 (count 7, bit 0 dropped), 10, 8 last.
        mem.delete();
        put_desc(TB, 0, 32'h8000, 32'h0000_0007);
        put_desc(TB, 1, 32'h8100, 32'h0000_000A);
        put_desc(TB, 2, 32'h8200, 32'h8000_0008);
        launch(0, TB, 24, 1, 0);
        chk_eq("R7", "done, exact fit", r_done, 1);
        chk_eq("R3", "eot after last region", r_eot, 1);
        chk_eq("R8", "no underrun exact fit", r_under, 0);
        chk_eq("R6", "bytes taken", r_moved, 24);
        chk_eq("R1", "descriptor reads", r_reads, 6);
        chk_region("R1", 32'h8000, 6, r_p0);
        chk_region("R1", 32'h8100, 10, r_p0 + 6);
        chk_region("R1", 32'h8200, 8, r_p0 + 16);
        chk_eq("R2", "byte past even length untouched", rd8(32'h8006), 0);

        // Device count ends inside region 2.
        mem.delete();
        put_desc(TB, 0, 32'h8000, 32'h0000_0007);
        put_desc(TB, 1, 32'h8100, 32'h0000_000A);
        put_desc(TB, 2, 32'h8200, 32'h8000_0008);
        launch(0, TB, 13, 1, 0);
        chk_eq("R4", "done mid region", r_done, 1);
        chk_eq("R4", "no eot mid region", r_eot, 0);
        chk_eq("R4", "bytes moved", r_moved, 13);
        chk_eq("R4", "no fetch past need", r_reads, 4);
        chk_region("R4", 32'h8100, 7, r_p0 + 6);
        chk_eq("R4", "region rest untouched", rd8(32'h8107), 0);

        // Device wants more than the table holds.
        mem.delete();
        put_desc(TB, 0, 32'h8000, 32'h0000_0007);
        put_desc(TB, 1, 32'h8100, 32'h0000_000A);
        put_desc(TB, 2, 32'h8200, 32'h8000_0008);
        launch(0, TB, 40, 1, 0);
        chk_eq("R8", "underrun", r_under, 1);
        chk_eq("R8", "eot with underrun", r_eot, 1);
        chk_eq("R8", "no done on underrun", r_done, 0);
        chk_eq("R3", "moved table total", r_moved, 24);
        chk_eq("R3", "no read after last", r_reads, 6);

        // Rewind: 16 bytes still owed, latched base reused.
        launch(1, 32'h5000, 0, 1, 0);
        chk_eq("R11", "done after rewind", r_done, 1);
        chk_eq("R11", "remaining bytes moved", r_moved, 16);
        chk_eq("R11", "reads from latched base", r_reads, 4);
        chk_eq("R11", "no eot", r_eot, 0);
        chk_region("R11", 32'h8000, 6, r_p0);
        chk_region("R11", 32'h8100, 10, r_p0 + 6);

        // Memory to device with stalls; unaligned base and buffer.
        mem.delete();
        stall_mode = 1'b1;
        put_desc(32'h2000, 0, 32'h9000, 32'h0000_000C);
        put_desc(32'h2000, 1, 32'h9403, 32'h8000_0010);
        for (int i = 0; i < 12; i++) mem[32'h9000 + i] = src(32'h9000 + i);
        for (int i = 0; i < 16; i++) mem[32'h9403 + i] = src(32'h9403 + i);
        launch(0, 32'h2003, 20, 0, 0);
        begin
            int bad;
            bad = 0;
            for (int i = 0; i < 12; i++)
                if (!rx.exists(r_p0 + i) || rx[r_p0 + i] != src(32'h9000 + i)) bad++;
            for (int i = 0; i < 8; i++)
                if (!rx.exists(r_p0 + 12 + i) || rx[r_p0 + 12 + i] != src(32'h9403 + i)) bad++;
            chk_eq("R6", "pushed bytes mismatching", bad, 0);
        end
        chk_eq("R6", "bytes pushed", r_moved, 20);
        chk_eq("R10", "reads from aligned base", r_reads, 9);
        chk_eq("R9", "done with stalls", r_done, 1);
        stall_mode = 1'b0;

        // Zero length means 64 KiB.
        mem.delete();
        put_desc(TB, 0, 32'h10000, 32'h8000_0000);
        launch(0, TB, 65540, 1, 0);
        chk_eq("R2", "64 KiB moved", r_moved, 65536);
        chk_eq("R2", "underrun after 64 KiB", r_under, 1);
        chk_region("R2", 32'h10000, 65536, r_p0);
        chk_eq("R2", "byte past 64 KiB untouched", rd8(32'h20000), 0);

        // Page limit: 600 unterminated descriptors, only 512 read.
        mem.delete();
        for (int i = 0; i < 600; i++)
            put_desc(32'h4000, i, 32'h40000 + 4*i, 32'h0000_0002);
        launch(0, 32'h4000, 5000, 1, 0);
        chk_eq("R5", "descriptor reads one page", r_reads, 1024);
        chk_eq("R5", "bytes moved", r_moved, 1024);
        chk_eq("R5", "eot at page limit", r_eot, 1);
        chk_eq("R5", "underrun at page limit", r_under, 1);
        chk_region("R5", 32'h40000 + 4*511, 2, r_p0 + 1022);
        chk_eq("R5", "region beyond page untouched", rd8(32'h40000 + 4*512), 0);

        // Zero device count: done, no access.
        launch(0, TB, 0, 1, 0);
        chk_eq("R7", "done on zero count", r_done, 1);
        chk_eq("R7", "no reads on zero count", r_reads, 0);
        chk_eq("R7", "no bytes on zero count", r_moved, 0);

        // go while busy is ignored.
        mem.delete();
        put_desc(TB, 0, 32'h8000, 32'h0000_0007);
        put_desc(TB, 1, 32'h8100, 32'h0000_000A);
        put_desc(TB, 2, 32'h8200, 32'h8000_0008);
        launch(0, TB, 24, 1, 5);
        chk_eq("R10", "moved despite go", r_moved, 24);
        chk_eq("R10", "reads despite go", r_reads, 6);
        chk_eq("R10", "done despite go", r_done, 1);
        chk_region("R10", 32'h8200, 8, r_p0 + 16);
        @(negedge clk);
        chk_eq("R10", "idle after walk", busy, 0);

        finish_up();
    end
endmodule